// File: doc/BRIEF.md
# Multi-Error Correction Apply Unit

This block finishes the correction of one 512-byte data chunk after a syndrome and error-locator engine has done the algebra. A job is offered on a valid/ready request. If the syndrome was zero the job ends at once. Otherwise the unit pulses a start to the locator engine. It then passes through a guard wait, because the engine's state code reads "addresses ready" for a short time before real work begins. After that it waits for a final state code. When the engine reports error locations, the unit takes up to four address/value pairs, which arrive packed two per 32-bit word. It turns each raw location into a byte index and applies every in-range error with a read, XOR and write on a synchronous byte-wide buffer port.

The request side follows valid/ready rules. A job is accepted in the cycle where `job_valid` and `job_ready` are both high. `job_ready` is high only while the unit is idle. A request offered while the unit is busy is not taken and has no effect, and the requester must hold it until it is accepted. The completion side is a one-cycle `done` pulse. The count and the failure flag stay stable after the pulse until the next job is accepted.

Top module: `ecc_fix_unit`

## Requirements
- R1: `job_ready` is 1 only while idle. A job is accepted only when `job_valid` and `job_ready` are both 1, and no buffer access happens while idle.
- R2: A job accepted with `syn_nonzero`=0 ends with a `done` pulse, `corr_cnt`=0 and `uncorrectable`=0. It makes no `calc_go` pulse and no buffer access.
- R3: A job with `syn_nonzero`=1 gives a single-cycle `calc_go` pulse. The unit then ignores `eng_state` until it reads 4 or more, or until `WAIT_TMO` cycles have passed. Expiry of that wait is not an error.
- R4: In the final wait, `eng_state`=0 ends the job with `corr_cnt`=0, `uncorrectable`=0 and no buffer access. Codes 4 to 15 keep the unit waiting.
- R5: In the final wait, `eng_state`=1 ends the job with `uncorrectable`=1, `corr_cnt`=0 and no buffer access.
- R6: In the final wait, `eng_state`=2 or 3 captures the words, and the number of errors is `err_cnt_fld`+1, from 1 to 4.
- R7: Error k (k = 0..3) comes from word k/2 (word 0 for errors 0 and 1, word 1 for errors 2 and 3). Odd k uses bits 31:16 of that word and even k uses bits 15:0. The raw address is bits 9:0 of the half-word and the value is bits 7:0.
- R8: The byte index is 519 minus the raw address. Only results in 0..511 (raw 8..519) are applied. Other entries are skipped with no buffer access.
- R9: Each applied error reads the byte, then writes (read data XOR value) to the same index two cycles later. Errors are applied in order of k, so repeated indices accumulate.
- R10: `corr_cnt` equals the number of applied errors. `done` is a one-cycle pulse, and `corr_cnt`/`uncorrectable` hold until the next accepted job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| job_valid | input | 1 | Correction job request |
| job_ready | output | 1 | Unit idle, request can be accepted |
| syn_nonzero | input | 1 | Syndrome of the chunk is nonzero (sampled at acceptance) |
| calc_go | output | 1 | One-cycle start pulse to the locator engine |
| eng_state | input | 4 | Engine state code (0 clean, 1 uncorrectable, 2/3 ready, 4+ busy) |
| err_cnt_fld | input | 2 | Error count minus one |
| err_addr_w0 | input | 32 | Raw addresses for errors 0 (low) and 1 (high) |
| err_addr_w1 | input | 32 | Raw addresses for errors 2 (low) and 3 (high) |
| err_val_w0 | input | 32 | Values for errors 0 (low) and 1 (high) |
| err_val_w1 | input | 32 | Values for errors 2 (low) and 3 (high) |
| buf_en | output | 1 | Buffer access enable |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 9 | Buffer byte index |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after a read |
| done | output | 1 | Job complete pulse |
| corr_cnt | output | 3 | Number of bytes corrected |
| uncorrectable | output | 1 | Engine reported too many errors |

## Verification
The bench shows stale location words while the engine's early "ready" code is presented. A unit that skipped the guard wait would latch those words and flip the wrong bytes. A separate case never shows a busy code, so a unit without the timeout would hang, and one that treated expiry as a failure would leave the data uncorrected. Raw locations of 3 and 1023 check that out-of-range entries are skipped without being counted, and junk in the upper bits of each half-word catches a missing field mask. A case with two errors on the same byte catches a read-modify-write that loses the first update. A case with three errors checks that the fourth slot is left alone even though it holds a legal location.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int MAX_ERR = 4;
  localparam int CNT_W   = $clog2(MAX_ERR + 1);
  localparam int IDX_W   = $clog2(MAX_ERR);

  typedef enum logic [3:0] {
    S_IDLE,
    S_KICK,
    S_ARM,
    S_SETTLE,
    S_PICK,
    S_RD,
    S_MOD,
    S_WR,
    S_FIN
  } fix_state_t;

  localparam logic [3:0] CODE_CLEAN = 4'd0;
  localparam logic [3:0] CODE_FAIL  = 4'd1;
  localparam logic [3:0] CODE_BUSY  = 4'd4;
endpackage

// File: rtl/ecc_slot_pick.sv
module ecc_slot_pick #(
  parameter int RAW_W = 10,
  parameter int VAL_W = 8
) (
  input  logic [1:0][31:0]  addr_words,
  input  logic [1:0][31:0]  val_words,
  input  logic [ecc_fix_pkg::IDX_W-1:0] idx,
  output logic [RAW_W-1:0]  raw_addr,
  output logic [VAL_W-1:0]  err_val
);
  localparam int HALF = 16;

  logic [1:0][HALF-1:0] addr_half;
  logic [1:0][HALF-1:0] val_half;

  // idx[1] picks the word, idx[0] picks the half inside it
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign addr_half[h] = addr_words[idx[1]][h*HALF +: HALF];
    assign val_half[h]  = val_words[idx[1]][h*HALF +: HALF];
  end

  assign raw_addr = addr_half[idx[0]][RAW_W-1:0];
  assign err_val  = val_half[idx[0]][VAL_W-1:0];
endmodule

// File: rtl/ecc_loc_xlate.sv
module ecc_loc_xlate #(
  parameter int RAW_W      = 10,
  parameter int DATA_BYTES = 512,
  parameter int ADDR_BIAS  = 519
) (
  input  logic [RAW_W-1:0]              raw_addr,
  output logic [$clog2(DATA_BYTES)-1:0] byte_idx,
  output logic                          in_range
);
  localparam int BA_W = $clog2(DATA_BYTES);
  localparam int DW   = RAW_W + 2;

  logic [DW-1:0] diff;

  assign diff     = DW'(ADDR_BIAS) - DW'(raw_addr);
  assign in_range = !diff[DW-1] && (diff < DW'(DATA_BYTES));
  assign byte_idx = diff[BA_W-1:0];
endmodule

// File: rtl/ecc_arm_timer.sv
module ecc_arm_timer #(
  parameter int WAIT_TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(WAIT_TMO + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (run && !expired)   cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == TW'(WAIT_TMO - 1));
endmodule

// File: rtl/ecc_fix_unit.sv
module ecc_fix_unit #(
  parameter int DATA_BYTES = 512,
  parameter int ADDR_BIAS  = 519,
  parameter int RAW_W      = 10,
  parameter int VAL_W      = 8,
  parameter int WAIT_TMO   = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          job_valid,
  output logic                          job_ready,
  input  logic                          syn_nonzero,
  output logic                          calc_go,
  input  logic [3:0]                    eng_state,
  input  logic [1:0]                    err_cnt_fld,
  input  logic [31:0]                   err_addr_w0,
  input  logic [31:0]                   err_addr_w1,
  input  logic [31:0]                   err_val_w0,
  input  logic [31:0]                   err_val_w1,
  output logic                          buf_en,
  output logic                          buf_we,
  output logic [$clog2(DATA_BYTES)-1:0] buf_addr,
  output logic [VAL_W-1:0]              buf_wdata,
  input  logic [VAL_W-1:0]              buf_rdata,
  output logic                          done,
  output logic [ecc_fix_pkg::CNT_W-1:0] corr_cnt,
  output logic                          uncorrectable
);
  import ecc_fix_pkg::*;

  localparam int BA_W = $clog2(DATA_BYTES);

  fix_state_t          st, st_nx;
  logic [1:0][31:0]    addr_q, val_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    last_q;
  logic [VAL_W-1:0]    fix_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                fail_q;
  logic [RAW_W-1:0]    raw_cur;
  logic [VAL_W-1:0]    val_cur;
  logic [BA_W-1:0]     idx_byte;
  logic                idx_ok;
  logic                tmo_hit;
  logic                accept;
  logic                is_last;

  assign accept  = job_valid && job_ready;
  assign is_last = (idx_q == last_q);

  ecc_slot_pick #(.RAW_W(RAW_W), .VAL_W(VAL_W)) pick_i (
    .addr_words (addr_q),
    .val_words  (val_q),
    .idx        (idx_q),
    .raw_addr   (raw_cur),
    .err_val    (val_cur)
  );

  ecc_loc_xlate #(.RAW_W(RAW_W), .DATA_BYTES(DATA_BYTES), .ADDR_BIAS(ADDR_BIAS)) xlate_i (
    .raw_addr (raw_cur),
    .byte_idx (idx_byte),
    .in_range (idx_ok)
  );

  ecc_arm_timer #(.WAIT_TMO(WAIT_TMO)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st == S_KICK),
    .run     (st == S_ARM),
    .expired (tmo_hit)
  );

  // next-state decode
  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:   if (accept) st_nx = syn_nonzero ? S_KICK : S_FIN;
      S_KICK:   st_nx = S_ARM;
      S_ARM:    if (eng_state >= CODE_BUSY || tmo_hit) st_nx = S_SETTLE;
      S_SETTLE: begin
        if (eng_state == CODE_CLEAN || eng_state == CODE_FAIL) st_nx = S_FIN;
        else if (eng_state < CODE_BUSY)                        st_nx = S_PICK;
      end
      S_PICK:   begin
        if (idx_ok)       st_nx = S_RD;
        else if (is_last) st_nx = S_FIN;
      end
      S_RD:     st_nx = S_MOD;
      S_MOD:    st_nx = S_WR;
      S_WR:     st_nx = is_last ? S_FIN : S_PICK;
      S_FIN:    st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  // job results and slot walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
      val_q  <= '0;
      fix_q  <= '0;
    end else begin
      if (accept) begin
        cnt_q  <= '0;
        fail_q <= 1'b0;
      end
      if (st == S_SETTLE) begin
        if (eng_state == CODE_FAIL) fail_q <= 1'b1;
        if (eng_state > CODE_FAIL && eng_state < CODE_BUSY) begin
          addr_q <= {err_addr_w1, err_addr_w0};
          val_q  <= {err_val_w1, err_val_w0};
          last_q <= IDX_W'(err_cnt_fld);
          idx_q  <= '0;
        end
      end
      if (st == S_PICK && !idx_ok && !is_last) idx_q <= idx_q + 1'b1;
      if (st == S_MOD) fix_q <= buf_rdata ^ val_cur;
      if (st == S_WR) begin
        cnt_q <= cnt_q + 1'b1;
        if (!is_last) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign job_ready     = (st == S_IDLE);
  assign calc_go       = (st == S_KICK);
  assign buf_en        = (st == S_RD) || (st == S_WR);
  assign buf_we        = (st == S_WR);
  assign buf_addr      = buf_en ? idx_byte : '0;
  assign buf_wdata     = buf_we ? fix_q : '0;
  assign done          = (st == S_FIN);
  assign corr_cnt      = cnt_q;
  assign uncorrectable = fail_q;
endmodule

// File: rtl/ecc_fix_unit_chk.sv
module ecc_fix_unit_chk #(
  parameter int BA_W  = 9,
  parameter int CNT_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            job_ready,
  input logic            calc_go,
  input logic            buf_en,
  input logic            buf_we,
  input logic [BA_W-1:0] buf_addr,
  input logic            done,
  input logic [CNT_W-1:0] corr_cnt,
  input logic            uncorrectable
);
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> !buf_en); // R1

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go |=> !calc_go); // R3

  AST_FAIL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> !buf_en); // R5

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && buf_we) |-> ($past(buf_en, 2) && !$past(buf_we, 2) && buf_addr == $past(buf_addr, 2))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (corr_cnt <= CNT_W'(4))); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (job_ready && $past(job_ready) && !$past(done)) |-> ($stable(corr_cnt) && $stable(uncorrectable))); // R10
endmodule

bind ecc_fix_unit ecc_fix_unit_chk #(.BA_W($clog2(DATA_BYTES)), .CNT_W(ecc_fix_pkg::CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .job_ready     (job_ready),
  .calc_go       (calc_go),
  .buf_en        (buf_en),
  .buf_we        (buf_we),
  .buf_addr      (buf_addr),
  .done          (done),
  .corr_cnt      (corr_cnt),
  .uncorrectable (uncorrectable)
);

// File: tb/ecc_fix_unit_tb_top.sv
module ecc_fix_unit_tb_top;
  localparam int NB  = 512;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic        syn_nonzero = 1'b0;
  logic        calc_go;
  logic [3:0]  eng_state = 4'd3;
  logic [1:0]  err_cnt_fld = 2'd0;
  logic [31:0] err_addr_w0 = '0, err_addr_w1 = '0, err_val_w0 = '0, err_val_w1 = '0;
  logic        buf_en, buf_we;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_wdata;
  logic [7:0]  buf_rdata;
  logic        done;
  logic [2:0]  corr_cnt;
  logic        uncorrectable;

  logic        ld_en = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  mem [NB];
  logic [7:0]  exp_mem [NB];
  int          wr_cnt = 0;
  int          go_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  ecc_fix_unit #(.WAIT_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .syn_nonzero(syn_nonzero), .calc_go(calc_go), .eng_state(eng_state),
    .err_cnt_fld(err_cnt_fld), .err_addr_w0(err_addr_w0), .err_addr_w1(err_addr_w1),
    .err_val_w0(err_val_w0), .err_val_w1(err_val_w1), .buf_en(buf_en), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .done(done),
    .corr_cnt(corr_cnt), .uncorrectable(uncorrectable)
  );

  // synchronous byte buffer model, one-cycle read latency
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (buf_en && buf_we) begin
      mem[buf_addr] <= buf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (buf_en) buf_rdata <= mem[buf_addr];
    if (calc_go) go_cnt <= go_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mem_compare(input string tag);
    int diffs = 0;
    for (int i = 0; i < NB; i++) if (mem[i] !== exp_mem[i]) diffs++;
    chk(diffs == 0, tag, diffs, 0);
  endtask

  // bench model of the correction list
  task automatic model_apply(input logic [1:0] fld, input logic [31:0] a0, a1, v0, v1,
                             output int napplied);
    napplied = 0;
    for (int k = 0; k <= int'(fld); k++) begin
      logic [31:0] aw, vw;
      int raw, val;
      aw  = (k < 2) ? a0 : a1;
      vw  = (k < 2) ? v0 : v1;
      raw = (k % 2 == 1) ? int'(aw[25:16]) : int'(aw[9:0]);
      val = (k % 2 == 1) ? int'(vw[23:16]) : int'(vw[7:0]);
      if (raw >= 8 && raw <= 519) begin
        exp_mem[519 - raw] = exp_mem[519 - raw] ^ 8'(val);
        napplied++;
      end
    end
  endtask

  // offer a job and play the engine; returns cycles from calc_go to done
  task automatic run_job(input bit syn, input int early, input int busyc, input logic [3:0] fin,
                         input logic [1:0] fld, input logic [31:0] a0, a1, v0, v1,
                         output int lat, output bit got_done);
    int go_seen = 0;
    lat = 0;
    got_done = 0;
    @(negedge clk);
    eng_state   = 4'd3;
    err_cnt_fld = 2'd3;
    err_addr_w0 = 32'h0100_0100; err_addr_w1 = 32'h0100_0100;
    err_val_w0  = 32'h005A_005A; err_val_w1  = 32'h005A_005A;
    syn_nonzero = syn;
    job_valid   = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;
    if (syn) begin
      for (int c = 0; c < 50 && !calc_go; c++) @(negedge clk);
      for (int c = 0; c < early; c++) @(negedge clk);
      if (busyc == 0) begin
        err_cnt_fld = fld;
        err_addr_w0 = a0; err_addr_w1 = a1; err_val_w0 = v0; err_val_w1 = v1;
        eng_state = fin;
      end else begin
        eng_state = 4'd9;
        for (int c = 0; c < busyc; c++) @(negedge clk);
        err_cnt_fld = fld;
        err_addr_w0 = a0; err_addr_w1 = a1; err_val_w0 = v0; err_val_w1 = v1;
        eng_state = fin;
      end
      lat = early + busyc;
      go_seen = 1;
    end
    for (int c = 0; c < 3000; c++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
      lat++;
    end
    if (go_seen == 0) lat = 0;
  endtask

  task automatic t_reset();
    chk(job_ready == 1'b1, "R1 ready after reset", job_ready, 1);
    chk(done == 1'b0 && buf_en == 1'b0 && calc_go == 1'b0, "R1 quiet after reset", buf_en, 0);
    chk(corr_cnt == 3'd0 && uncorrectable == 1'b0, "R10 reset results", corr_cnt, 0);
  endtask

  task automatic t_zero_syndrome();
    int lat, g0, w0, n; bit d;
    g0 = go_cnt; w0 = wr_cnt;
    run_job(1'b0, 0, 0, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, lat, d);
    chk(d, "R2 done on zero syndrome", d, 1);
    chk(corr_cnt == 0 && !uncorrectable, "R2 zero count", corr_cnt, 0);
    chk(go_cnt == g0, "R2 no calc_go", go_cnt - g0, 0);
    chk(wr_cnt == w0, "R2 no writes", wr_cnt - w0, 0);
    n = 0;
    mem_compare("R2 buffer untouched");
  endtask

  task automatic t_four_errors();
    int lat, n, w0, g0; bit d;
    logic [31:0] a0, a1, v0, v1;
    a0 = {16'hFCC8, 16'hA80A};   // raw1 200 -> 319, raw0 10 -> 509 (junk above bit 9)
    a1 = {16'h012C, 16'h0207};   // raw3 300 -> 219, raw2 519 -> 0
    v0 = 32'hEE3C_7781;
    v1 = 32'h9911_22FF;
    w0 = wr_cnt; g0 = go_cnt;
    model_apply(2'd3, a0, a1, v0, v1, n);
    fork
      run_job(1'b1, 5, 6, 4'd2, 2'd3, a0, a1, v0, v1, lat, d);
      begin
        // mid-job request must be ignored while busy
        repeat (6) @(negedge clk);
        chk(job_ready == 1'b0, "R1 not ready while busy", job_ready, 0);
        job_valid = 1'b1;
        @(negedge clk);
        job_valid = 1'b0;
      end
    join
    chk(d, "R6 done four errors", d, 1);
    chk(int'(corr_cnt) == n, "R10 count four errors", corr_cnt, n);
    chk(wr_cnt - w0 == n, "R9 one write per error", wr_cnt - w0, n);
    chk(go_cnt - g0 == 1, "R1 busy request ignored", go_cnt - g0, 1);
    mem_compare("R3 R7 R8 buffer after four errors");
    repeat (3) @(negedge clk);
    chk(int'(corr_cnt) == n && job_ready, "R10 result held", corr_cnt, n);
  endtask

  task automatic t_skip_range();
    int lat, n, w0; bit d;
    logic [31:0] a0, a1, v0, v1;
    a0 = {16'h0207, 16'h0003};   // raw1 519 -> 0, raw0 3 -> 516 skip
    a1 = {16'h0000, 16'h03FF};   // raw2 1023 -> skip
    v0 = 32'h0024_0011; v1 = 32'h0000_0077;
    w0 = wr_cnt;
    model_apply(2'd2, a0, a1, v0, v1, n);
    run_job(1'b1, 3, 4, 4'd3, 2'd2, a0, a1, v0, v1, lat, d);
    chk(d && int'(corr_cnt) == n, "R8 out-of-range not counted", corr_cnt, n);
    chk(wr_cnt - w0 == 1, "R8 skipped entries not written", wr_cnt - w0, 1);
    mem_compare("R8 buffer after skip case");
  endtask

  task automatic t_uncorrectable();
    int lat, w0; bit d;
    w0 = wr_cnt;
    run_job(1'b1, 2, 3, 4'd1, 2'd3, 32'h0010_0010, 32'h0010_0010, 32'h00FF_00FF, 32'h00FF_00FF, lat, d);
    chk(d && uncorrectable, "R5 uncorrectable flag", uncorrectable, 1);
    chk(corr_cnt == 0 && wr_cnt == w0, "R5 no correction", wr_cnt - w0, 0);
    mem_compare("R5 buffer untouched");
  endtask

  task automatic t_clean_state();
    int lat, w0; bit d;
    w0 = wr_cnt;
    run_job(1'b1, 2, 5, 4'd0, 2'd3, 32'h0010_0010, 32'h0010_0010, 32'h00FF_00FF, 32'h00FF_00FF, lat, d);
    chk(d && !uncorrectable && corr_cnt == 0, "R4 clean code ends job", corr_cnt, 0);
    chk(wr_cnt == w0, "R4 no writes on clean code", wr_cnt - w0, 0);
  endtask

  task automatic t_timeout();
    int lat, n; bit d;
    logic [31:0] a0;
    a0 = 32'h0000_0008;          // raw0 8 -> 511
    model_apply(2'd0, a0, 32'h0, 32'h0000_0042, 32'h0, n);
    run_job(1'b1, 0, 0, 4'd3, 2'd0, a0, 32'h0, 32'h0000_0042, 32'h0, lat, d);
    chk(d && corr_cnt == 1 && !uncorrectable, "R3 timeout continues", corr_cnt, 1);
    chk(lat >= TMO, "R3 guard wait length", lat, TMO);
    mem_compare("R3 buffer after timeout case");
  endtask

  task automatic t_three_errors();
    int lat, n; bit d;
    logic [31:0] a0, a1, v0, v1;
    a0 = {16'd101, 16'd100}; a1 = {16'd103, 16'd102};
    v0 = 32'h0002_0001; v1 = 32'h0008_0004;
    model_apply(2'd2, a0, a1, v0, v1, n);
    run_job(1'b1, 4, 2, 4'd2, 2'd2, a0, a1, v0, v1, lat, d);
    chk(d && corr_cnt == 3, "R6 three errors counted", corr_cnt, 3);
    mem_compare("R7 fourth slot ignored");
  endtask

  task automatic t_same_byte();
    int lat, n; bit d;
    logic [31:0] a0, v0;
    a0 = {16'd50, 16'd50}; v0 = 32'h00F0_000F;
    model_apply(2'd1, a0, 32'h0, v0, 32'h0, n);
    run_job(1'b1, 2, 2, 4'd3, 2'd1, a0, 32'h0, v0, 32'h0, lat, d);
    chk(d && corr_cnt == 2, "R9 repeated index counted", corr_cnt, 2);
    chk(mem[469] == exp_mem[469], "R9 repeated index accumulates", mem[469], exp_mem[469]);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < NB; i++) begin
      ld_en = 1'b1; ld_addr = 9'(i); ld_data = 8'((i * 7 + 3) & 8'hFF);
      exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      @(negedge clk);
    end
    ld_en = 1'b0;
    t_zero_syndrome();
    t_four_errors();
    t_skip_range();
    t_uncorrectable();
    t_clean_state();
    t_timeout();
    t_three_errors();
    t_same_byte();
    finish_run();
  end
endmodule